// File: doc/BRIEF.md
# Processor Interrupt Entry and Masking Unit

This block holds the processor status word (mode field plus the asynchronous-abort, IRQ and FIQ mask bits) and decides when the core takes an interrupt exception. Two request lines, IRQ and FIQ, are level-sensitive and active low. They are synchronized and then compared against the mask bits. When one is accepted, the block saves the current PC and status word into that exception's banked registers. It then switches mode, sets the needed mask bits, and emits a one-cycle redirect strobe carrying the vector address.

Software changes mask bits with a set/clear command that names any subset of A, I and F. An exception-return request restores the banked status word and redirects to the banked link value minus 4. A strap is sampled only while reset is held. When the strap is active, software can no longer set F, but FIQ entry still sets F.

Top module: `irq_entry_unit`

## Requirements
- R1: While rst_n is low at a rising edge, the status becomes Supervisor mode with A, I and F all set. This reads as status_o = 0xF3, where status_o[7]=A, [6]=I, [5]=F and [4:0]=mode, with Supervisor = 0x13. redirect_o is 0.
- R2: Requests are active low and pass through a two-stage synchronizer. An unmasked request applied before rising edge n raises redirect_o after edge n+2, for exactly one cycle.
- R3: No IRQ entry occurs while I is set. A request held low through the mask is taken once I is cleared.
- R4: IRQ entry does four things: it saves pc_i as the IRQ link value and the status word as the IRQ saved status; it sets mode 0x12 and I; it leaves A and F unchanged; and it outputs redirect_pc_o = vec_base_i + 0x18.
- R5: FIQ entry saves into the FIQ bank, sets mode 0x11, sets I and F, and outputs redirect_pc_o = vec_base_i + 0x1C.
- R6: When both requests are pending and FIQ is unmasked, FIQ is taken. IRQ cannot then enter while in the FIQ handler, because I is set.
- R7: A mask command (mask_valid_i) has a select field mask_sel_i, with [2]=A, [1]=I and [0]=F. When mask_enable_i=1 the selected bits are cleared; when it is 0 they are set. Unselected bits and the mode keep their values.
- R8: If nmfiq_strap_i was high during reset, a set command leaves F unchanged. Clear commands and FIQ entry still change F.
- R9: The reset status is 0xF3 whatever value the strap has.
- R10: In IRQ or FIQ mode, ret_valid_i restores that mode's saved status and redirects to its link value minus 4. If the restored I is clear, a pending IRQ is then taken.
- R11: ret_valid_i outside IRQ and FIQ mode has no effect: no redirect and no status change.
- R12: An interrupt entry takes precedence over a return and a mask command in the same cycle. An effective return takes precedence over a mask command. In both cases the lower-priority request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmfiq_strap_i | input | 1 | Non-maskable FIQ strap, sampled during reset |
| irq_n_i | input | 1 | IRQ request, active low |
| fiq_n_i | input | 1 | FIQ request, active low |
| vec_base_i | input | AW | Vector table base address |
| pc_i | input | AW | Current PC of the interrupted program |
| mask_valid_i | input | 1 | Mask command strobe |
| mask_enable_i | input | 1 | 1 clears selected bits, 0 sets them |
| mask_sel_i | input | 3 | Bit select: [2]=A, [1]=I, [0]=F |
| ret_valid_i | input | 1 | Exception return request |
| redirect_o | output | 1 | One-cycle PC redirect strobe |
| redirect_pc_o | output | AW | Redirect target address |
| status_o | output | 8 | Status word {A, I, F, mode[4:0]} |

## Verification
The assertions assume three things: the strap matters only during reset, the command and return strobes are sampled only on rising edges, and vec_base_i is stable while an entry is being evaluated. The bench drives every input just after a falling edge and keeps vec_base_i and pc_i constant around each interrupt. It changes the strap only while rst_n is held low. It also releases requests only while the matching mask bit is already set, so no entry happens that the bench did not plan for.

// File: rtl/irq_entry_pkg.sv
// Shared encodings and the status-word type for the interrupt entry unit.
// Assumes a 5-bit mode field and three mask bits packed above it.
package irq_entry_pkg;
    localparam logic [4:0] MODE_FIQ = 5'h11;
    localparam logic [4:0] MODE_IRQ = 5'h12;
    localparam logic [4:0] MODE_SVC = 5'h13;
    localparam logic [4:0] MODE_SYS = 5'h1F;

    localparam int IRQ_VEC_OFS = 'h18;
    localparam int FIQ_VEC_OFS = 'h1C;
    localparam int RET_ADJUST  = 4;

    // Bank indices for the saved link/status registers.
    localparam int BANK_IRQ = 0;
    localparam int BANK_FIQ = 1;
    localparam int N_BANKS  = 2;

    typedef struct packed {
        logic       a;
        logic       i;
        logic       f;
        logic [4:0] mode;
    } psw_t;

    localparam psw_t PSW_RESET = '{a: 1'b1, i: 1'b1, f: 1'b1, mode: MODE_SVC};
endpackage

// File: rtl/req_sync.sv
// Multi-stage synchronizer for a vector of asynchronous request lines.
// Assumes requests are levels held for longer than STAGES cycles; resets to RST_VAL.
module req_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the request vector one stage per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else if (s == 0) stg[s] <= din;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

    p_sync_reset_r2: assert property (@(posedge clk) !rst_n |=> (dout == RST_VAL))
        else $error("synchronizer not idle after reset");
endmodule

// File: rtl/exc_bank.sv
// One banked register pair (link value and saved status) for an exception mode.
// Assumes save_i is a single-cycle strobe coincident with entry into that mode.
module exc_bank
    import irq_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_i,
    input  logic [AW-1:0] pc_i,
    input  psw_t          psw_i,
    output logic [AW-1:0] lr_o,
    output psw_t          spsr_o
);
    // Capture return address and status word on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_o   <= '0;
            spsr_o <= PSW_RESET;
        end else if (save_i) begin
            lr_o   <= pc_i;
            spsr_o <= psw_i;
        end
    end
endmodule

// File: rtl/mask_update.sv
// Combinational next-value of the mask bits for a set/clear command.
// Assumes sel bit order {A, I, F}; nm blocks software from setting F.
module mask_update
    import irq_entry_pkg::*;
(
    input  psw_t       cur_i,
    input  logic       enable_i,
    input  logic [2:0] sel_i,
    input  logic       nm_i,
    output psw_t       nxt_o
);
    // Apply the command only to the named bits.
    always_comb begin
        nxt_o = cur_i;
        if (enable_i) begin
            if (sel_i[2]) nxt_o.a = 1'b0;
            if (sel_i[1]) nxt_o.i = 1'b0;
            if (sel_i[0]) nxt_o.f = 1'b0;
        end else begin
            if (sel_i[2]) nxt_o.a = 1'b1;
            if (sel_i[1]) nxt_o.i = 1'b1;
            if (sel_i[0] && !nm_i) nxt_o.f = 1'b1;
        end
    end
endmodule

// File: rtl/irq_entry_unit.sv
// Status word, interrupt acceptance, banked state saving, mask commands and
// exception return. Assumes strobes are sampled on rising edges and the
// strap is meaningful only while reset is held.
module irq_entry_unit
    import irq_entry_pkg::*;
#(
    parameter int AW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmfiq_strap_i,
    input  logic          irq_n_i,
    input  logic          fiq_n_i,
    input  logic [AW-1:0] vec_base_i,
    input  logic [AW-1:0] pc_i,
    input  logic          mask_valid_i,
    input  logic          mask_enable_i,
    input  logic [2:0]    mask_sel_i,
    input  logic          ret_valid_i,
    output logic          redirect_o,
    output logic [AW-1:0] redirect_pc_o,
    output logic [7:0]    status_o
);
    localparam logic [AW-1:0] IRQ_OFS = AW'(IRQ_VEC_OFS);
    localparam logic [AW-1:0] FIQ_OFS = AW'(FIQ_VEC_OFS);
    localparam logic [AW-1:0] RET_ADJ = AW'(RET_ADJUST);

    psw_t          psw;
    psw_t          mask_nxt;
    logic          nm_q;
    logic [1:0]    req_sync_n;
    logic          irq_pend, fiq_pend;
    logic          take_irq, take_fiq, take_any;
    logic          in_irq, in_fiq, ret_fire, mask_fire;
    logic [AW-1:0] bank_lr   [N_BANKS];
    psw_t          bank_spsr [N_BANKS];
    logic [AW-1:0] ret_lr;
    psw_t          ret_psw;

    req_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({fiq_n_i, irq_n_i}),
        .dout  (req_sync_n)
    );

    // Acceptance: FIQ first, IRQ only if FIQ is not taken.
    always_comb begin
        irq_pend  = !req_sync_n[0];
        fiq_pend  = !req_sync_n[1];
        take_fiq  = fiq_pend && !psw.f;
        take_irq  = irq_pend && !psw.i && !take_fiq;
        take_any  = take_fiq || take_irq;
        in_irq    = (psw.mode == MODE_IRQ);
        in_fiq    = (psw.mode == MODE_FIQ);
        ret_fire  = ret_valid_i && (in_irq || in_fiq) && !take_any;
        mask_fire = mask_valid_i && !take_any && !ret_fire;
        ret_lr    = in_fiq ? bank_lr[BANK_FIQ]   : bank_lr[BANK_IRQ];
        ret_psw   = in_fiq ? bank_spsr[BANK_FIQ] : bank_spsr[BANK_IRQ];
    end

    genvar b;
    generate
        for (b = 0; b < N_BANKS; b++) begin : g_bank
            exc_bank #(.AW(AW)) i_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .save_i ((b == BANK_FIQ) ? take_fiq : take_irq),
                .pc_i   (pc_i),
                .psw_i  (psw),
                .lr_o   (bank_lr[b]),
                .spsr_o (bank_spsr[b])
            );
        end
    endgenerate

    mask_update i_mask (
        .cur_i    (psw),
        .enable_i (mask_enable_i),
        .sel_i    (mask_sel_i),
        .nm_i     (nm_q),
        .nxt_o    (mask_nxt)
    );

    // Status word, strap latch and redirect output, by event priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw           <= PSW_RESET;
            nm_q          <= nmfiq_strap_i;
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
        end else begin
            redirect_o <= take_any || ret_fire;
            if (take_fiq) begin
                psw.mode      <= MODE_FIQ;
                psw.i         <= 1'b1;
                psw.f         <= 1'b1;
                redirect_pc_o <= vec_base_i + FIQ_OFS;
            end else if (take_irq) begin
                psw.mode      <= MODE_IRQ;
                psw.i         <= 1'b1;
                redirect_pc_o <= vec_base_i + IRQ_OFS;
            end else if (ret_fire) begin
                psw           <= ret_psw;
                redirect_pc_o <= ret_lr - RET_ADJ;
            end else if (mask_fire) begin
                psw <= mask_nxt;
            end
        end
    end

    assign status_o = psw;

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (psw == PSW_RESET && !redirect_o))
        else $error("reset state wrong");

    p_irq_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> (redirect_o && psw.mode == MODE_IRQ && psw.i
                      && redirect_pc_o == $past(vec_base_i) + IRQ_OFS))
        else $error("IRQ entry wrong");

    p_fiq_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_fiq |=> (redirect_o && psw.mode == MODE_FIQ && psw.i && psw.f
                      && redirect_pc_o == $past(vec_base_i) + FIQ_OFS))
        else $error("FIQ entry wrong");

    p_fiq_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_pend && irq_pend && !psw.f) |=> (psw.mode == MODE_FIQ))
        else $error("IRQ beat FIQ");

    p_nm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nm_q && mask_fire && !mask_enable_i && mask_sel_i[0] && !psw.f) |=> !psw.f)
        else $error("F set by software while non-maskable");

    p_ret_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |=> (redirect_o && redirect_pc_o == $past(ret_lr) - RET_ADJ))
        else $error("return target wrong");

    p_ret_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_i && !take_any && !in_irq && !in_fiq && !mask_valid_i)
        |=> (!redirect_o && $stable(psw)))
        else $error("return outside exception mode acted");
endmodule

// File: tb/test_irq_entry_unit.sv
// Self-checking bench: mask-command sweep plus directed entry/return cases.
module test_irq_entry_unit;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap = 1'b0;
    logic          irq_n = 1'b1, fiq_n = 1'b1;
    logic [AW-1:0] vec_base = 32'h8000_0000;
    logic [AW-1:0] pc = 32'h0000_1000;
    logic          mvalid = 1'b0, men = 1'b0;
    logic [2:0]    msel = 3'b000;
    logic          rvalid = 1'b0;
    logic          redirect;
    logic [AW-1:0] redirect_pc;
    logic [7:0]    status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    irq_entry_unit #(.AW(AW)) i_irq_entry_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .nmfiq_strap_i (strap),
        .irq_n_i       (irq_n),
        .fiq_n_i       (fiq_n),
        .vec_base_i    (vec_base),
        .pc_i          (pc),
        .mask_valid_i  (mvalid),
        .mask_enable_i (men),
        .mask_sel_i    (msel),
        .ret_valid_i   (rvalid),
        .redirect_o    (redirect),
        .redirect_pc_o (redirect_pc),
        .status_o      (status)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0;
        strap = s;
        irq_n = 1'b1;
        fiq_n = 1'b1;
        repeat (3) cyc();
        strap = ~s;   // strap must not matter after reset
        rst_n = 1'b1;
    endtask

    task automatic mask_cmd(input logic en, input logic [2:0] sel);
        mvalid = 1'b1;
        men = en;
        msel = sel;
        cyc();
        mvalid = 1'b0;
    endtask

    task automatic do_ret();
        rvalid = 1'b1;
        cyc();
        rvalid = 1'b0;
    endtask

    // Count cycles until redirect shows, up to a limit.
    task automatic wait_redirect(output int lat);
        lat = 0;
        do begin
            cyc();
            lat++;
        end while (!redirect && lat < 10);
    endtask

    function automatic logic [2:0] model(input logic [2:0] cur, input logic en,
                                         input logic [2:0] sel, input logic nm);
        if (en) return cur & ~sel;
        return cur | (sel & (nm ? 3'b110 : 3'b111));
    endfunction

    initial begin
        int lat;
        logic [2:0] cur;

        // R1 / R9: reset state with strap low and high.
        do_reset(1'b0);
        chk("R1 reset status", AW'(status), 32'hF3);
        chk("R1 reset redirect", AW'(redirect), 0);
        do_reset(1'b1);
        chk("R9 reset status with strap", AW'(status), 32'hF3);

        // R7 / R8: exhaustive sweep of start state, select and direction.
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            cur = 3'b111;
            for (int st = 0; st < 8; st++) begin
                for (int sel = 0; sel < 8; sel++) begin
                    for (int en = 0; en < 2; en++) begin
                        mask_cmd(1'b1, ~st[2:0]);
                        cur = model(cur, 1'b1, ~st[2:0], s[0]);
                        mask_cmd(1'b0, st[2:0]);
                        cur = model(cur, 1'b0, st[2:0], s[0]);
                        mask_cmd(en[0], sel[2:0]);
                        cur = model(cur, en[0], sel[2:0], s[0]);
                        chk(s[0] ? "R8 mask with strap" : "R7 mask command",
                            AW'(status), AW'({cur, 5'h13}));
                    end
                end
            end
        end

        // R2 / R4: IRQ entry latency, state, strobe width.
        do_reset(1'b0);
        mask_cmd(1'b1, 3'b111);
        pc = 32'h1000_0040;
        irq_n = 1'b0;
        wait_redirect(lat);
        chk("R2 IRQ latency", AW'(lat), 3);
        chk("R4 IRQ vector", redirect_pc, 32'h8000_0018);
        chk("R4 IRQ status", AW'(status), 32'h52);
        cyc();
        chk("R2 strobe one cycle", AW'(redirect), 0);
        irq_n = 1'b1;
        repeat (3) cyc();
        chk("R3 no re-entry while I set", AW'(status), 32'h52);

        // R10: return restores state and target.
        do_ret();
        chk("R10 return strobe", AW'(redirect), 1);
        chk("R10 return target", redirect_pc, 32'h1000_003C);
        chk("R10 return status", AW'(status), 32'h13);

        // R11: return in Supervisor mode ignored.
        do_ret();
        chk("R11 ignored return redirect", AW'(redirect), 0);
        chk("R11 ignored return status", AW'(status), 32'h13);

        // R3: masked IRQ held low, taken after I cleared.
        mask_cmd(1'b0, 3'b010);
        pc = 32'h2000_0100;
        irq_n = 1'b0;
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            cyc();
            if (redirect) lat++;
        end
        chk("R3 masked IRQ no redirect", AW'(lat), 0);
        mask_cmd(1'b1, 3'b010);
        cyc();
        chk("R3 taken after unmask", AW'(redirect), 1);
        chk("R3 status after unmask", AW'(status), 32'h52);
        irq_n = 1'b1;
        repeat (3) cyc();
        // R12: return beats a mask command in the same cycle.
        mvalid = 1'b1; men = 1'b0; msel = 3'b100;
        do_ret();
        mvalid = 1'b0;
        chk("R12 return over command", AW'(status), 32'h13);
        chk("R10 return target 2", redirect_pc, 32'h2000_00FC);

        // R5 / R6: both pending, FIQ wins; IRQ taken after FIQ return.
        pc = 32'h3000_0200;
        irq_n = 1'b0;
        fiq_n = 1'b0;
        wait_redirect(lat);
        chk("R6 FIQ latency", AW'(lat), 3);
        chk("R5 FIQ vector", redirect_pc, 32'h8000_001C);
        chk("R5 FIQ status", AW'(status), 32'h71);
        fiq_n = 1'b1;
        repeat (4) cyc();
        chk("R6 IRQ blocked in FIQ", AW'(status), 32'h71);
        pc = 32'h4000_0000;
        do_ret();
        chk("R10 FIQ return target", redirect_pc, 32'h3000_01FC);
        chk("R10 FIQ return status", AW'(status), 32'h13);
        cyc();
        chk("R10 IRQ re-enabled and taken", AW'(redirect), 1);
        chk("R10 IRQ vector after return", redirect_pc, 32'h8000_0018);
        irq_n = 1'b1;
        repeat (3) cyc();
        do_ret();
        chk("R10 IRQ link from pc_i", redirect_pc, 32'h3FFF_FFFC);

        // R12: entry beats a mask command in the same cycle.
        irq_n = 1'b0;
        cyc();
        cyc();
        mask_cmd(1'b0, 3'b100);
        chk("R12 entry over command", AW'(status), 32'h52);
        irq_n = 1'b1;
        repeat (3) cyc();
        do_ret();

        // R8: strap blocks software F set, FIQ entry still sets F.
        do_reset(1'b1);
        mask_cmd(1'b1, 3'b111);
        mask_cmd(1'b0, 3'b001);
        chk("R8 F set blocked", AW'(status), 32'h13);
        fiq_n = 1'b0;
        wait_redirect(lat);
        chk("R8 FIQ entry sets F", AW'(status), 32'h71);
        fiq_n = 1'b1;
        repeat (3) cyc();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule